// File: doc/BRIEF.md
# Serial ROM Slot Emulator

This block stands in for a plug-in read-only module on a bit-serial calculator bus. The bus repeats a word cycle of 56 pulses on the second of two non-overlapping clock phases. A frame marker line shows where the cycle stands, and a power-good line lets the host put its peripherals to sleep. All bus lines reach the block already synchronised to its own fast system clock. The block finds the edges of each line itself and counts phase-B pulses to know its position in the cycle.

During pulses 16 to 31 the host sends a 16-bit fetch address on the shared instruction line. The block collects it least significant bit first and compares the top four bits with its configured page. On a match it fetches a 10-bit word from a ROM image fixed at elaboration time. From pulse 46 it sends that word back on the same line, least significant bit first. The line driver is split into a data bit and an output enable, so the block releases the line whenever it is not replying.

After a power-on wakeup the host always begins with a fetch from address 0. The block therefore aligns on the first falling edge of the frame marker it sees and then counts freely from there.

Top module: `romslot_emu`

## Requirements
- R1: During reset and after it, until the block has aligned to a cycle, `line_oe` and `line_out` are low.
- R2: A falling edge of `frame` makes the next phase-B pulse pulse 0. Pulses then count up to 55 and wrap to 0, even if no further `frame` edge arrives.
- R3: On each rising edge of `ph_a` during pulses 16 to 31, the block samples `line_in`. The first sample becomes address bit 0 and the sixteenth becomes bit 15.
- R4: The block replies only when address bits 15:12 equal `BASE_PAGE`. For any other address, `line_oe` stays low for the whole cycle.
- R5: The reply is ROM_IMAGE word n, which occupies bits [10n+9:10n] of the parameter. It is sent bit 0 first, so the 8 low bits go before the 2 high bits. Bit k is valid while `ph_b` is high in pulse 46+k, and the output steps to the next bit on each falling edge of `ph_b`.
- R6: In a replying cycle, `line_oe` rises just after the rising edge of `ph_b` in pulse 46 and falls just after the falling edge of `ph_b` in pulse 55. It is high for exactly 10 pulses.
- R7: If `frame` is low at the rising edge of `ph_b` in pulse 46, the block does not reply in that cycle, even when the address matches.
- R8: If `pwr_on` is low at the falling edge of `ph_b` in pulse 2, the block goes idle and does not reply in that cycle. Once `pwr_on` is high again, it realigns at the next falling edge of `frame`.
- R9: The word index n is the address taken modulo ROM_WORDS, that is its low log2(ROM_WORDS) bits. The image therefore repeats across the page.
- R10: `line_out` is low whenever `line_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph_a | input | 1 | Bus clock phase A (address sampling phase), synchronised |
| ph_b | input | 1 | Bus clock phase B (pulse counting phase), synchronised |
| frame | input | 1 | Frame marker; its falling edge ends a word cycle |
| pwr_on | input | 1 | Host power-good; low puts the block to sleep |
| line_in | input | 1 | Received value of the shared instruction line |
| line_out | output | 1 | Data bit driven onto the instruction line |
| line_oe | output | 1 | Output enable for the instruction line driver |

## Verification
The bench builds the block with `BASE_PAGE` = 5 and a 64-word image whose words are computed from their index. With a small image, addresses past offset 63 inside the page can show the wrap-around of R9. Page 5 lets a miss whose page differs only in bit 15 (page D) show that every page bit is compared. The image covers all four values of the upper two bits, so the order of the low and high parts of the reply is observable.

// File: rtl/romslot_pkg.sv
package romslot_pkg;

    // widths of the bus words
    localparam int ADDR_W  = 16;
    localparam int PAGE_W  = 4;
    localparam int WORD_W  = 10;
    localparam int LO_W    = 8;
    localparam int HI_W    = WORD_W - LO_W;
    localparam int PULSE_W = 6;
    localparam int LEFT_W  = $clog2(WORD_W);

    typedef logic [PULSE_W-1:0] pulse_t;
    typedef logic [WORD_W-1:0]  word_t;

    // fixed positions inside the 56-pulse word cycle
    localparam pulse_t LAST_PULSE  = pulse_t'(55);
    localparam pulse_t PWR_PULSE   = pulse_t'(2);
    localparam pulse_t ADDR_FIRST  = pulse_t'(16);
    localparam pulse_t ADDR_LAST   = pulse_t'(31);
    localparam pulse_t FETCH_LO_AT = pulse_t'(33);
    localparam pulse_t FETCH_HI_AT = pulse_t'(34);
    localparam pulse_t TX_ARM_AT   = pulse_t'(45);

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_SEEK = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

    typedef struct packed {
        logic a;
        logic b;
        logic frm;
    } prev_t;

    typedef struct packed {
        mode_e  mode;
        pulse_t pulse;
    } seq_t;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } fetch_t;

    typedef struct packed {
        logic              active;
        word_t             shreg;
        logic [LEFT_W-1:0] left;
    } tx_t;

endpackage

// File: rtl/romslot_edges.sv
module romslot_edges
    import romslot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    input  logic frame,
    output logic a_rise,
    output logic b_rise,
    output logic b_fall,
    output logic frame_fall
);

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.a   = ph_a;
        prev_d.b   = ph_b;
        prev_d.frm = frame;
        a_rise     = ph_a & ~prev_q.a;
        b_rise     = ph_b & ~prev_q.b;
        b_fall     = ~ph_b & prev_q.b;
        frame_fall = ~frame & prev_q.frm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/romslot_seq.sv
module romslot_seq
    import romslot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   b_rise,
    input  logic   b_fall,
    input  logic   frame_fall,
    input  logic   pwr_on,
    output logic   run,
    output pulse_t pulse
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.mode)
            MODE_IDLE: begin
                if (pwr_on) seq_d.mode = MODE_SEEK;
            end
            MODE_SEEK: begin
                // the next phase-B pulse after the marker falls is pulse 0
                if (frame_fall) begin
                    seq_d.mode  = MODE_RUN;
                    seq_d.pulse = LAST_PULSE;
                end
            end
            MODE_RUN: begin
                if (frame_fall) begin
                    seq_d.pulse = LAST_PULSE;
                end else if (b_rise) begin
                    seq_d.pulse = (seq_q.pulse == LAST_PULSE) ? '0
                                                              : seq_q.pulse + pulse_t'(1);
                end
                if (b_fall && seq_q.pulse == PWR_PULSE && !pwr_on) begin
                    seq_d.mode  = MODE_IDLE;
                    seq_d.pulse = '0;
                end
            end
            default: begin
                seq_d.mode  = MODE_IDLE;
                seq_d.pulse = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.mode  <= MODE_IDLE;
            seq_q.pulse <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run   = (seq_q.mode == MODE_RUN);
    assign pulse = seq_q.pulse;

endmodule

// File: rtl/romslot_addr.sv
module romslot_addr
    import romslot_pkg::*;
#(
    parameter logic [PAGE_W-1:0] BASE_PAGE = 4'h8,
    parameter int                OFS_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  pulse_t           pulse,
    input  logic             a_rise,
    input  logic             line_in,
    output logic             hit,
    output logic [OFS_W-1:0] offset
);

    logic [ADDR_W-1:0] shreg_d, shreg_q;
    logic              in_window;

    always_comb begin
        in_window = (pulse >= ADDR_FIRST) && (pulse <= ADDR_LAST);
        shreg_d   = shreg_q;
        // least significant bit arrives first, so shift in from the top
        if (run && a_rise && in_window)
            shreg_d = {line_in, shreg_q[ADDR_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= shreg_d;
    end

    assign hit    = (shreg_q[ADDR_W-1 -: PAGE_W] == BASE_PAGE);
    assign offset = shreg_q[OFS_W-1:0];

endmodule

// File: rtl/romslot_rom.sv
module romslot_rom
    import romslot_pkg::*;
#(
    parameter int                        ROM_WORDS = 64,
    parameter logic [ROM_WORDS*WORD_W-1:0] ROM_IMAGE = '0,
    localparam int                       OFS_W     = $clog2(ROM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  pulse_t           pulse,
    input  logic             b_fall,
    input  logic [OFS_W-1:0] offset,
    output word_t            data
);

    word_t  rom_words [ROM_WORDS];
    word_t  sel_word;
    fetch_t fetch_d, fetch_q;

    for (genvar g = 0; g < ROM_WORDS; g++) begin : g_unpack
        assign rom_words[g] = ROM_IMAGE[g*WORD_W +: WORD_W];
    end

    always_comb begin
        sel_word = rom_words[offset];
        fetch_d  = fetch_q;
        // two partial reads, both finished well before the reply window
        if (run && b_fall && pulse == FETCH_LO_AT)
            fetch_d.lo = sel_word[LO_W-1:0];
        if (run && b_fall && pulse == FETCH_HI_AT)
            fetch_d.hi = sel_word[WORD_W-1:LO_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= '0;
        else        fetch_q <= fetch_d;
    end

    assign data = {fetch_q.hi, fetch_q.lo};

endmodule

// File: rtl/romslot_tx.sv
module romslot_tx
    import romslot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  pulse_t pulse,
    input  logic   b_rise,
    input  logic   b_fall,
    input  logic   frame,
    input  logic   hit,
    input  word_t  data,
    output logic   line_out,
    output logic   line_oe
);

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!run) begin
            tx_d.active = 1'b0;
        end else if (!tx_q.active) begin
            if (b_rise && pulse == TX_ARM_AT && frame && hit) begin
                tx_d.active = 1'b1;
                tx_d.shreg  = data;
                tx_d.left   = LEFT_W'(WORD_W - 1);
            end
        end else if (b_fall) begin
            if (tx_q.left == '0) begin
                tx_d.active = 1'b0;
            end else begin
                tx_d.shreg = {1'b0, tx_q.shreg[WORD_W-1:1]};
                tx_d.left  = tx_q.left - LEFT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign line_oe  = tx_q.active;
    assign line_out = tx_q.active & tx_q.shreg[0];

endmodule

// File: rtl/romslot_emu.sv
module romslot_emu
    import romslot_pkg::*;
#(
    parameter logic [PAGE_W-1:0]           BASE_PAGE = 4'h8,
    parameter int                          ROM_WORDS = 64,
    parameter logic [ROM_WORDS*WORD_W-1:0] ROM_IMAGE = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    input  logic frame,
    input  logic pwr_on,
    input  logic line_in,
    output logic line_out,
    output logic line_oe
);

    localparam int OFS_W = $clog2(ROM_WORDS);

    logic             a_rise, b_rise, b_fall, frame_fall;
    logic             run;
    pulse_t           pulse;
    logic             hit;
    logic [OFS_W-1:0] offset;
    word_t            data;

    romslot_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph_a       (ph_a),
        .ph_b       (ph_b),
        .frame      (frame),
        .a_rise     (a_rise),
        .b_rise     (b_rise),
        .b_fall     (b_fall),
        .frame_fall (frame_fall)
    );

    romslot_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .b_rise     (b_rise),
        .b_fall     (b_fall),
        .frame_fall (frame_fall),
        .pwr_on     (pwr_on),
        .run        (run),
        .pulse      (pulse)
    );

    romslot_addr #(
        .BASE_PAGE (BASE_PAGE),
        .OFS_W     (OFS_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pulse   (pulse),
        .a_rise  (a_rise),
        .line_in (line_in),
        .hit     (hit),
        .offset  (offset)
    );

    romslot_rom #(
        .ROM_WORDS (ROM_WORDS),
        .ROM_IMAGE (ROM_IMAGE)
    ) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pulse  (pulse),
        .b_fall (b_fall),
        .offset (offset),
        .data   (data)
    );

    romslot_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pulse    (pulse),
        .b_rise   (b_rise),
        .b_fall   (b_fall),
        .frame    (frame),
        .hit      (hit),
        .data     (data),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

endmodule

// File: rtl/romslot_checker.sv
module romslot_checker (
    input logic clk,
    input logic rst_n,
    input logic ph_b,
    input logic frame,
    input logic hit,
    input logic line_out,
    input logic line_oe
);

    // R10: a released line carries no data
    a_r10_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_out);

    // R6: enable follows a rising edge of phase B
    a_r6_enable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> ($past(ph_b) && !$past(ph_b, 2)));

    // R6: release follows a falling edge of phase B
    a_r6_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> (!$past(ph_b) && $past(ph_b, 2)));

    // R5: data bits step only after a falling edge of phase B
    a_r5_step_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe) && (line_out != $past(line_out)))
            |-> (!$past(ph_b) && $past(ph_b, 2)));

    // R7: a reply starts only with the frame marker high
    a_r7_frame_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> $past(frame));

    // R4: the line is driven only for an address inside the page
    a_r4_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> hit);

endmodule

bind romslot_emu romslot_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_b     (ph_b),
    .frame    (frame),
    .hit      (hit),
    .line_out (line_out),
    .line_oe  (line_oe)
);

// File: tb/romslot_emu_test.sv
`timescale 1ns/1ps
module romslot_emu_test;

    localparam logic [3:0] PAGE  = 4'h5;
    localparam int         WORDS = 64;

    function automatic logic [9:0] img_word(int i);
        return 10'((i * 149 + 677) % 1024);
    endfunction

    function automatic logic [WORDS*10-1:0] build_image();
        logic [WORDS*10-1:0] img;
        img = '0;
        for (int i = 0; i < WORDS; i++) img[i*10 +: 10] = img_word(i);
        return img;
    endfunction

    localparam logic [WORDS*10-1:0] IMAGE = build_image();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_a = 1'b0, ph_b = 1'b0, frame = 1'b0, pwr_on = 1'b1, line_in = 1'b0;
    logic line_out, line_oe;

    always #2 clk = ~clk;

    romslot_emu #(
        .BASE_PAGE (PAGE),
        .ROM_WORDS (WORDS),
        .ROM_IMAGE (IMAGE)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_a     (ph_a),
        .ph_b     (ph_b),
        .frame    (frame),
        .pwr_on   (pwr_on),
        .line_in  (line_in),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    typedef struct {
        bit    oe;
        bit    dat;
        int    pulse;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: compares the line in the middle of every phase-B high period
    initial begin
        forever begin
            @(posedge ph_b);
            repeat (3) @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (line_oe !== e.oe || line_out !== (e.oe ? e.dat : 1'b0)) begin
                    n_fail++;
                    $display("FAIL %s pulse %0d: actual oe=%0b out=%0b expected oe=%0b out=%0b",
                             e.tag, e.pulse, line_oe, line_out, e.oe, e.oe ? e.dat : 1'b0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        summary();
        $finish;
    end

    // driver: one phase-B pulse, with the expectation pushed before it
    task automatic bus_pulse(int p, bit frm, bit pwr, logic [15:0] a, bit push, exp_t e);
        @(negedge clk);
        frame   = frm;
        pwr_on  = pwr;
        line_in = (p >= 16 && p <= 31) ? a[p-16] : 1'b0;
        if (push) exp_q.push_back(e);
        repeat (2) @(negedge clk);
        ph_b = 1'b1;
        repeat (4) @(negedge clk);
        ph_b = 1'b0;
        repeat (2) @(negedge clk);
        ph_a = 1'b1;
        repeat (3) @(negedge clk);
        ph_a = 1'b0;
    endtask

    task automatic bus_cycle(logic [15:0] a, bit frame_ok, bit pwr_drop, string tag);
        bit         hit;
        logic [9:0] w;
        hit = (a[15:12] == PAGE);
        w   = img_word(int'(a[5:0]));          // R9: low 6 bits index the 64 words
        for (int p = 0; p < 56; p++) begin
            exp_t e;
            bit   drive;
            drive   = hit && frame_ok && !pwr_drop && (p >= 46);
            e.oe    = drive;
            e.dat   = drive ? w[p-46] : 1'b0;
            e.pulse = p;
            e.tag   = drive ? {tag, " R5 R6"} : {tag, " R6 R10"};
            bus_pulse(p, frame_ok && (p >= 46), pwr_drop ? (p >= 20) : 1'b1, a, 1'b1, e);
        end
    endtask

    initial begin
        exp_t none;
        none.oe = 0; none.dat = 0; none.pulse = 0; none.tag = "";
        repeat (10) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (line_oe !== 1'b0 || line_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual oe=%0b out=%0b expected oe=0 out=0", line_oe, line_out);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        n_chk++;
        if (line_oe !== 1'b0 || line_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual oe=%0b out=%0b expected oe=0 out=0", line_oe, line_out);
        end
        // tail of a cycle before alignment; nothing may be driven (R1)
        for (int p = 40; p < 56; p++) bus_pulse(p, p >= 46, 1'b1, 16'h5000, 1'b0, none);

        bus_cycle(16'h0000, 1, 0, "R2 R4 wakeup fetch");
        bus_cycle(16'h5000, 1, 0, "R3 R5 first word");
        bus_cycle(16'h5003, 1, 0, "R3");
        bus_cycle(16'h5155, 1, 0, "R3 alternating bits");
        bus_cycle(16'h502A, 1, 0, "R3");
        bus_cycle(16'h503F, 1, 0, "R9 last word");
        bus_cycle(16'h5040, 1, 0, "R9 alias to word 0");
        bus_cycle(16'h5FFF, 1, 0, "R9 top of page");
        bus_cycle(16'h4FFF, 1, 0, "R4 page below");
        bus_cycle(16'h6000, 1, 0, "R4 page above");
        bus_cycle(16'hD005, 1, 0, "R4 bit15 differs");
        bus_cycle(16'h5011, 0, 0, "R7 frame low");
        bus_cycle(16'h5025, 1, 0, "R2 wrap without marker");
        bus_cycle(16'h5012, 1, 1, "R8 power low");
        bus_cycle(16'h5013, 1, 0, "R8 realigned");

        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

endmodule